// File: doc/BRIEF.md
# Serial Frame Transmitter with Graceful Disable

This block turns bytes into asynchronous serial frames on one output line. Software or an upstream block writes bytes into a small on-chip queue. The frame engine pulls each byte from that queue and sends it as a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Configuration inputs set the data length, the parity mode and the stop count. A strobe that pulses at sixteen times the bit rate sets the timing. Baud-rate division is done outside the block.

Two enables gate the start of a new frame: a block enable and a transmit enable. Both are expected high straight out of reset, so the block sends without any setup step. If either enable drops while a frame is on the line, that frame still runs to its last stop bit. No further byte leaves the queue until both enables are high again. The whole frame is built when it starts, so configuration changes made while a frame is on the line apply only to later frames.

Top module: `serial_tx`

## Requirements
- R1: After reset, the line is high, busy is low, the empty flag is high, and the full and overflow flags are low.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. The data length is 5 + len_sel_i (0 gives 5 bits, 3 gives 8 bits). Data bits above the selected length are not sent.
- R3: The parity bit follows the data bits. par_sel_i selects the mode: 0 none (no bit is sent), 1 even (the bit makes the count of ones, data plus parity, even), 2 odd, 3 constant 0, 4 constant 1.
- R4: After the parity bit, or after the data when parity is off, come one high stop bit, or two when stop2_i is 1. Between frames the line idles high.
- R5: Every bit of the frame lasts exactly 16 tick_i pulses. No bit advances without a tick.
- R6: The queue holds 16 bytes and sends them in the order written. The full flag is high with 16 entries stored, and the empty flag is high with none.
- R7: A write while the queue is full is dropped and sets the overflow flag. That flag stays set until reset.
- R8: A frame starts only while en_i and tx_en_i are both high. If either falls mid-frame, the current frame completes, and no new frame starts while it stays low.
- R9: The data length, parity mode and stop count are taken when a frame starts. Changes made during the frame do not alter it.
- R10: busy_o is high from the first tick period of the start bit through the last tick of the final stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| tx_en_i | input | 1 | Transmit enable |
| tick_i | input | 1 | Strobe at 16x the bit rate |
| wr_i | input | 1 | Queue write strobe |
| wr_data_i | input | 8 | Byte to queue |
| len_sel_i | input | 2 | Data length select, length = 5 + value |
| par_sel_i | input | 3 | Parity mode select |
| stop2_i | input | 1 | Two stop bits when 1 |
| txd_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| overflow_o | output | 1 | Sticky write-drop flag |

## Verification
The bench targets four risks:
- Disable mid-frame. Enable is dropped a few bits into a frame. An engine that aborts leaves the frame truncated. An engine that ignores the enable sends the next queued byte while disabled.
- Overflow. The queue is filled to 16 with transmission paused, then written once more. An off-by-one in the full logic either loses the sixteenth byte or lets a seventeenth frame out. The overflow flag is checked for staying set after the queue drains.
- Configuration changed mid-frame. The configuration is changed while a frame is on the line. A design that reads it live sends a malformed frame.
- Frame length. Ticks are counted across each busy period. A wrong bit count shows up in odd frame shapes such as 5 data bits with two stop bits, or stick parity.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;
endpackage

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr, fill;
  logic              wr_ok;

  assign fill      = wr_ptr - rd_ptr;
  assign full_o    = (fill == DEPTH[AW:0]);
  assign empty_o   = (fill == '0);
  assign wr_ok     = wr_i && !full_o;
  assign rd_data_o = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (wr_ok)            wr_ptr     <= wr_ptr + 1'b1;
      if (rd_i && !empty_o) rd_ptr     <= rd_ptr + 1'b1;
      if (wr_i && full_o)   overflow_o <= 1'b1;
    end
  end

  assert_full_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i) |=> (full_o && $stable(wr_ptr)));
  assert_ovf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_no_empty_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
endmodule

// File: rtl/serial_tx_pack.sv
module serial_tx_pack
  import serial_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_MAX = DATA_W + 4,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic [DATA_W-1:0]    data_i,
  input  logic [1:0]           len_sel_i,
  input  logic [2:0]           par_sel_i,
  input  logic                 stop2_i,
  output logic [FRAME_MAX-1:0] frame_o,
  output logic [CNT_W-1:0]     nbits_o
);
  localparam int MIN_LEN = DATA_W - 3;

  int   len;
  logic ones;
  logic par_on;
  logic par_bit;

  always_comb begin
    len     = MIN_LEN + int'(len_sel_i);
    frame_o = '1;        // stop bits and padding stay high
    frame_o[0] = 1'b0;   // start
    ones    = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < len) begin
        frame_o[1+i] = data_i[i];
        ones         = ones ^ data_i[i];
      end
    end
    par_on = 1'b1;
    unique case (par_sel_i)
      PAR_EVEN: par_bit = ones;
      PAR_ODD:  par_bit = ~ones;
      PAR_ZERO: par_bit = 1'b0;
      PAR_ONE:  par_bit = 1'b1;
      default: begin
        par_bit = 1'b1;
        par_on  = 1'b0;
      end
    endcase
    if (par_on) frame_o[1+len] = par_bit;
    nbits_o = CNT_W'(2 + len + int'(par_on) + int'(stop2_i));
  end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift #(
  parameter int FRAME_MAX = 12,
  parameter int OSR       = 16,
  parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_MAX-1:0] frame_i,
  input  logic [CNT_W-1:0]     nbits_i,
  input  logic                 tick_i,
  output logic                 busy_o,
  output logic                 txd_o
);
  localparam int TW = $clog2(OSR);

  logic [FRAME_MAX-1:0] sr;
  logic [TW-1:0]        tick_cnt;
  logic [CNT_W-1:0]     left;
  logic                 bit_end;

  assign bit_end = tick_i && (tick_cnt == TW'(OSR - 1));
  assign txd_o   = busy_o ? sr[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      sr       <= '1;
      tick_cnt <= '0;
      left     <= '0;
    end else if (!busy_o) begin
      if (load_i) begin
        busy_o   <= 1'b1;
        sr       <= frame_i;
        tick_cnt <= '0;
        left     <= nbits_i;
      end
    end else if (tick_i) begin
      tick_cnt <= tick_cnt + 1'b1;
      if (bit_end) begin
        sr   <= {1'b1, sr[FRAME_MAX-1:1]};
        left <= left - 1'b1;
        if (left == CNT_W'(1)) busy_o <= 1'b0;
      end
    end
  end

  assert_hold_no_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (busy_o && $stable(sr) && $stable(left)));
  assert_no_load_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && !bit_end) |=> (busy_o && $stable(left)));
endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tx_en_i,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        len_sel_i,
  input  logic [2:0]        par_sel_i,
  input  logic              stop2_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overflow_o
);
  localparam int FRAME_MAX = DATA_W + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [DATA_W-1:0]    head;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     nbits;
  logic                 go;

  assign go = en_i && tx_en_i && !busy_o && !empty_o;

  serial_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .rd_i(go), .rd_data_o(head), .empty_o, .full_o, .overflow_o
  );

  serial_tx_pack #(.DATA_W(DATA_W), .FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_pack (
    .data_i(head), .len_sel_i, .par_sel_i, .stop2_i,
    .frame_o(frame), .nbits_o(nbits)
  );

  serial_tx_shift #(.FRAME_MAX(FRAME_MAX), .OSR(OSR), .CNT_W(CNT_W)) u_shift (
    .clk_i, .rst_ni, .load_i(go), .frame_i(frame), .nbits_i(nbits),
    .tick_i, .busy_o, .txd_o
  );

  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  assert_gated_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(en_i && tx_en_i)) |=> !busy_o);
  assert_idle_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> txd_o);
endmodule

// File: tb/serial_tx_tb.sv
module serial_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, tx_en = 1'b1, tick = 1'b0, wr = 1'b0, stop2 = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] len_sel = 2'd3;
  logic [2:0] par_sel = 3'd0;
  logic       txd, busy, empty, full, ovf;

  int checks = 0, errors = 0, tick_acc = 0;

  typedef struct {
    logic [7:0] d;
    int         len;
    logic [2:0] par;
    logic       two;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  serial_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tx_en_i(tx_en), .tick_i(tick),
    .wr_i(wr), .wr_data_i(wdata), .len_sel_i(len_sel), .par_sel_i(par_sel),
    .stop2_i(stop2), .txd_o(txd), .busy_o(busy), .empty_o(empty),
    .full_o(full), .overflow_o(ovf)
  );

  initial forever begin
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  end

  always @(posedge clk) begin
    if (!busy) tick_acc <= 0;
    else if (tick) tick_acc <= tick_acc + 1;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, expv);
    end
  endtask

  task automatic wr_raw(input logic [7:0] b);
    @(posedge clk); #1 wr = 1'b1; wdata = b;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    exp_t e;
    e.len = 5 + int'(len_sel);
    e.d   = b & 8'((1 << e.len) - 1);
    e.par = par_sel;
    e.two = stop2;
    exp_q.push_back(e);
    wr_raw(b);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  function automatic logic exp_par(input exp_t e);
    case (e.par)
      3'd1: return ^e.d;
      3'd2: return ~^e.d;
      3'd3: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic decode();
    exp_t e;
    bit have;
    logic [7:0] d;
    logic s, p, st1, st2;
    bit par_on, ok;
    int nb;
    have = exp_q.size() > 0;
    if (have) e = exp_q.pop_front();
    else begin e.d = 8'h00; e.len = 8; e.par = 3'd0; e.two = 1'b0; end
    par_on = (e.par >= 3'd1) && (e.par <= 3'd4);
    wait_ticks(8); s = txd;
    d = '0;
    for (int i = 0; i < e.len; i++) begin wait_ticks(16); d[i] = txd; end
    p = 1'b0;
    if (par_on) begin wait_ticks(16); p = txd; end
    wait_ticks(16); st1 = txd;
    st2 = 1'b1;
    if (e.two) begin wait_ticks(16); st2 = txd; end
    ok = have && !s && (d == e.d) && st1 && st2 && (!par_on || p == exp_par(e));
    // R2 R3 R4 R6 R9: decoded frame matches scoreboard head
    chk(ok, "R2/R3/R4 frame (data,par,stops)", {d, 3'b0, p, st1, st2, s}, {e.d, 3'b0, exp_par(e), 3'b110});
    nb = 2 + e.len + int'(par_on) + int'(e.two);
    do @(negedge clk); while (busy);
    // R5 R10: busy spans exactly 16 ticks per bit
    chk(tick_acc == 16 * nb, "R5/R10 ticks while busy", tick_acc, 16 * nb);
  endtask

  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !txd) begin
        decode();
        prev = 1'b1;
      end else prev = txd;
    end
  end

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || busy);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(empty == 1'b1, "R1 empty", empty, 1);
    chk(full == 1'b0 && ovf == 1'b0, "R1 full/ovf", {full, ovf}, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 8N1, enabled straight from reset
    len_sel = 2'd3; par_sel = 3'd0; stop2 = 1'b0;
    send(8'hA5); send(8'h3C); drain();
    // R2 R4 5 bits, even parity, two stops; upper bits masked
    len_sel = 2'd0; par_sel = 3'd1; stop2 = 1'b1;
    send(8'hFF); send(8'h0A); drain();
    // R3 odd, constant 0, constant 1
    len_sel = 2'd2; par_sel = 3'd2; stop2 = 1'b0;
    send(8'h55); send(8'h00); drain();
    len_sel = 2'd1; par_sel = 3'd3;
    send(8'h3F); drain();
    len_sel = 2'd2; par_sel = 3'd4; stop2 = 1'b1;
    send(8'h12); drain();

    // R6 R7 fill while paused, then overflow
    tx_en = 1'b0;
    len_sel = 2'd3; par_sel = 3'd1; stop2 = 1'b0;
    for (int i = 0; i < 15; i++) send(8'(i * 17 + 3));
    @(negedge clk);
    chk(full == 1'b0, "R6 not full at 15", full, 0);
    send(8'hE7);
    @(negedge clk);
    chk(full == 1'b1, "R6 full at 16", full, 1);
    chk(ovf == 1'b0, "R7 no overflow yet", ovf, 0);
    wr_raw(8'h99);
    @(negedge clk);
    chk(ovf == 1'b1, "R7 overflow set", ovf, 1);
    chk(busy == 1'b0, "R8 paused no start", busy, 0);
    tx_en = 1'b1;
    drain();
    repeat (600) @(negedge clk);
    chk(exp_q.size() == 0 && busy == 1'b0 && empty == 1'b1, "R7 dropped byte not sent", busy, 0);
    chk(ovf == 1'b1, "R7 overflow sticky", ovf, 1);

    // R8 graceful disable mid-frame
    len_sel = 2'd3; par_sel = 3'd0; stop2 = 1'b0;
    send(8'hC3); send(8'h5E);
    do @(negedge clk); while (!busy);
    repeat (60) @(negedge clk);
    en = 1'b0;
    do @(negedge clk); while (exp_q.size() != 1 || busy);
    repeat (800) @(negedge clk);
    chk(busy == 1'b0, "R8 stays idle while disabled", busy, 0);
    chk(empty == 1'b0, "R8 byte held in queue", empty, 0);
    en = 1'b1;
    drain();

    // R9 config changed mid-frame
    len_sel = 2'd3; par_sel = 3'd1; stop2 = 1'b1;
    send(8'h5A);
    do @(negedge clk); while (!busy);
    repeat (20) @(negedge clk);
    len_sel = 2'd0; par_sel = 3'd4; stop2 = 1'b0;
    drain();

    finish_run();
  end
endmodule